// File: doc/BRIEF.md
# Narrow Host Bus Endian Bridge

This block joins a narrow host processor port, either 8 or 16 bits wide, to a bank of 32-bit configuration registers. Host writes are gathered byte by byte or halfword by halfword into a holding word. The holding word goes to the register file when the final lane of the word arrives. Host reads fetch the whole 32-bit word once and then hand it back in narrow pieces from a snapshot.

Three mode inputs set how host addresses and data map onto register bits: `little_en` selects the endianness, `bus16` selects the bus width and `addr_inv` selects the kind of invariance. In big endian operation nothing is remapped. In little endian data-invariant operation the low address bits are remapped, so that integer values keep their meaning. In little endian address-invariant operation the addresses are kept. On a 16-bit bus the two data bytes are then exchanged.

Internally, byte lane 0 of a word is the most significant byte. The host's most significant data bit is wired to the most significant register bit.

Top module: `hostbus_endian_bridge`

## Requirements
- R1: With `little_en` low, the internal lane equals the host address low bits, whatever `bus16` and `addr_inv` are. In 16-bit mode only bit 1 of those low bits is used. Data bytes are not exchanged.
- R2: With `little_en` high, `bus16` low and `addr_inv` low, the internal lane is the host low address bits inverted: 00 and 11 trade places, and 01 and 10 trade places.
- R3: With `little_en` high, `bus16` high and `addr_inv` low, host halfword 00 selects internal halfword 10, and host halfword 10 selects internal halfword 00.
- R4: With `little_en`, `bus16` and `addr_inv` all high, the address is unchanged. The two bytes of the 16-bit bus are exchanged on both writes and reads.
- R5: With `little_en` high, `bus16` low and `addr_inv` high, neither the address nor the data is altered.
- R6: Internal byte lane k occupies register bits [31-8k : 24-8k]. On the 16-bit bus, bits 15:8 carry the lower-numbered lane of the pair, and host address bit 0 is ignored. In 8-bit mode, data travels on bits 7:0 and read bits 15:8 are zero.
- R7: A host write to the last internal lane asserts `reg_we` in the same cycle. The last lane is lane 3 in 8-bit mode and halfword 10 in 16-bit mode. `reg_wdata` is then the held lanes merged with the current one, and `reg_addr` is the host address above bit 1.
- R8: A host write to any other lane leaves `reg_we` low and only updates the holding word.
- R9: A host read of internal lane 0 asserts `reg_re` in the same cycle and snapshots `reg_rdata`. Each read's data appears on `host_rdata` in the cycle after the strobe and is held until the next read.
- R10: A host read of a lane other than 0 returns data from the snapshot, even if the register has changed since the snapshot was taken.
- R11: After reset, `host_rdata` is zero. `reg_we` and `reg_re` stay low while no strobe is given.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| host_addr | input | REG_ADDR_W+2 | Host byte address |
| host_wdata | input | 16 | Host write data (bits 7:0 in 8-bit mode) |
| host_wr | input | 1 | Host write strobe, one cycle per access |
| host_rd | input | 1 | Host read strobe, one cycle per access |
| bus16 | input | 1 | 1 = 16-bit host bus, 0 = 8-bit |
| little_en | input | 1 | 1 = little endian host |
| addr_inv | input | 1 | 1 = address-invariant, 0 = data-invariant |
| host_rdata | output | 16 | Read data, valid the cycle after `host_rd` |
| reg_addr | output | REG_ADDR_W | Register word address |
| reg_we | output | 1 | Register write enable |
| reg_wdata | output | 32 | Stacked register write word |
| reg_re | output | 1 | Register read enable (snapshot cycle) |
| reg_rdata | input | 32 | Register read word |

## Verification
The bench builds the block with `REG_ADDR_W` = 4, which gives 16 words. That is enough to give each of the six mode combinations its own word, plus a spare word for the snapshot test. Because the space is small, the bench can keep a full shadow of the register file and compare it with the model after every word. Words are written lane by lane in the model's own lane order, and out-of-order writes and odd halfword addresses are also exercised. The bench pokes a register between two reads, which shows whether later lanes come from the snapshot.

// File: rtl/hostbus_endian_bridge.sv
module hostbus_endian_bridge #(
  parameter int REG_ADDR_W = 6
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [REG_ADDR_W+1:0] host_addr,
  input  logic [15:0]           host_wdata,
  input  logic                  host_wr,
  input  logic                  host_rd,
  input  logic                  bus16,
  input  logic                  little_en,
  input  logic                  addr_inv,
  output logic [15:0]           host_rdata,
  output logic [REG_ADDR_W-1:0] reg_addr,
  output logic                  reg_we,
  output logic [31:0]           reg_wdata,
  output logic                  reg_re,
  input  logic [31:0]           reg_rdata
);
  localparam int AW = REG_ADDR_W + 2;

  logic [1:0]  hlo, xmask, lane;
  logic        dswap, last_lane, first_lane;
  logic [15:0] wd, rsel;
  logic [31:0] hold_w, snap, merged, src;

  assign hlo        = bus16 ? {host_addr[1], 1'b0} : host_addr[1:0];
  assign xmask      = (little_en && !addr_inv) ? (bus16 ? 2'b10 : 2'b11) : 2'b00;
  assign lane       = hlo ^ xmask;
  assign dswap      = little_en & addr_inv & bus16;
  assign wd         = dswap ? {host_wdata[7:0], host_wdata[15:8]} : host_wdata;
  assign last_lane  = bus16 ? lane[1] : (lane == 2'b11);
  assign first_lane = (lane == 2'b00);

  always_comb begin
    merged = hold_w;
    if (bus16) merged[31 - 16*int'(lane[1]) -: 16] = wd;
    else       merged[31 - 8*int'(lane) -: 8]      = wd[7:0];
  end

  assign reg_addr  = host_addr[AW-1:2];
  assign reg_we    = host_wr & last_lane;
  assign reg_wdata = merged;
  assign reg_re    = host_rd & first_lane;

  assign src = first_lane ? reg_rdata : snap;

  always_comb begin
    if (bus16) rsel = src[31 - 16*int'(lane[1]) -: 16];
    else       rsel = {8'h00, src[31 - 8*int'(lane) -: 8]};
    if (dswap) rsel = {rsel[7:0], rsel[15:8]};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_w     <= '0;
      snap       <= '0;
      host_rdata <= '0;
    end else begin
      if (host_wr) hold_w <= merged;
      if (host_rd) begin
        if (first_lane) snap <= reg_rdata;
        host_rdata <= rsel;
      end
    end
  end
endmodule

// File: rtl/hostbus_endian_bridge_sva.sv
module hostbus_endian_bridge_sva #(
  parameter int REG_ADDR_W = 6
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic [REG_ADDR_W+1:0] host_addr,
  input logic [15:0]           host_wdata,
  input logic                  host_wr,
  input logic                  host_rd,
  input logic                  bus16,
  input logic                  little_en,
  input logic                  addr_inv,
  input logic [15:0]           host_rdata,
  input logic                  reg_we,
  input logic [31:0]           reg_wdata,
  input logic                  reg_re
);
  p_we_needs_wr_r7: assert property (@(posedge clk) disable iff (!rst_n)
    reg_we |-> host_wr);

  p_re_needs_rd_r9: assert property (@(posedge clk) disable iff (!rst_n)
    reg_re |-> host_rd);

  p_no_commit_mid_word_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (host_wr && little_en && !bus16 && !addr_inv && host_addr[1:0] != 2'b00) |-> !reg_we);

  p_be_commit_last_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (host_wr && !little_en && !bus16 && host_addr[1:0] == 2'b11) |-> reg_we);

  p_rdata_held_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !host_rd |=> $stable(host_rdata));

  p_halfword_swap_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_we && bus16 && little_en && addr_inv) |-> (reg_wdata[7:0] == host_wdata[15:8]));

  p_narrow_read_hi_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (host_rd && !bus16) |=> (host_rdata[15:8] == 8'h00));
endmodule

bind hostbus_endian_bridge hostbus_endian_bridge_sva #(.REG_ADDR_W(REG_ADDR_W)) u_sva (
  .clk(clk), .rst_n(rst_n), .host_addr(host_addr), .host_wdata(host_wdata),
  .host_wr(host_wr), .host_rd(host_rd), .bus16(bus16), .little_en(little_en),
  .addr_inv(addr_inv), .host_rdata(host_rdata), .reg_we(reg_we),
  .reg_wdata(reg_wdata), .reg_re(reg_re)
);

// File: tb/hostbus_endian_bridge_bench.sv
`timescale 1ns/1ps
module hostbus_endian_bridge_bench;
  localparam int RAW = 4;
  localparam int AW  = RAW + 2;
  localparam int NW  = 1 << RAW;

  logic clk = 0, rst_n = 0;
  logic [AW-1:0]  host_addr = '0;
  logic [15:0]    host_wdata = '0;
  logic           host_wr = 0, host_rd = 0;
  logic           bus16 = 0, little_en = 0, addr_inv = 0;
  logic [15:0]    host_rdata;
  logic [RAW-1:0] reg_addr;
  logic           reg_we, reg_re;
  logic [31:0]    reg_wdata, reg_rdata;

  logic [31:0] mem [NW];
  logic [31:0] ref_mem [NW];
  logic [31:0] ref_hold = 0, ref_snap = 0;
  int errors = 0, checks = 0;
  bit done = 0;

  always #10 clk = ~clk;

  hostbus_endian_bridge #(.REG_ADDR_W(RAW)) u_hostbus_endian_bridge (
    .clk(clk), .rst_n(rst_n), .host_addr(host_addr), .host_wdata(host_wdata),
    .host_wr(host_wr), .host_rd(host_rd), .bus16(bus16), .little_en(little_en),
    .addr_inv(addr_inv), .host_rdata(host_rdata), .reg_addr(reg_addr),
    .reg_we(reg_we), .reg_wdata(reg_wdata), .reg_re(reg_re), .reg_rdata(reg_rdata)
  );

  assign reg_rdata = mem[reg_addr];
  always @(posedge clk) if (reg_we) mem[reg_addr] <= reg_wdata;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic string mode_tag();
    if (!little_en) return "R1";
    if (!addr_inv) return bus16 ? "R3" : "R2";
    return bus16 ? "R4" : "R5";
  endfunction

  function automatic int ref_lane(input logic [1:0] a);
    int h;
    h = bus16 ? 2 * int'(a[1]) : int'(a);
    if (little_en && !addr_inv) h = bus16 ? 2 - h : 3 - h;
    return h;
  endfunction

  function automatic logic [7:0] byte_at(input logic [31:0] w, input int k);
    return 8'((w >> (8 * (3 - k))) & 32'hFF);
  endfunction

  function automatic logic [31:0] put_byte(input logic [31:0] w, input int k, input logic [7:0] b);
    logic [31:0] m;
    m = 32'hFF << (8 * (3 - k));
    return (w & ~m) | ({24'h0, b} << (8 * (3 - k)));
  endfunction

  task automatic wr(input logic [AW-1:0] a, input logic [15:0] d);
    int ln;
    bit sw, exp_we;
    logic [7:0] b0, b1;
    ln = ref_lane(a[1:0]);
    sw = little_en && addr_inv && bus16;
    if (bus16) begin
      b0 = sw ? d[7:0] : d[15:8];
      b1 = sw ? d[15:8] : d[7:0];
      ref_hold = put_byte(put_byte(ref_hold, ln, b0), ln + 1, b1);
      exp_we = (ln == 2);
    end else begin
      ref_hold = put_byte(ref_hold, ln, d[7:0]);
      exp_we = (ln == 3);
    end
    @(negedge clk);
    host_addr = a; host_wdata = d; host_wr = 1;
    #1;
    if (exp_we) begin
      chk(reg_we == 1'b1, "R7 commit", {31'b0, reg_we}, 32'd1);
      chk(reg_wdata == ref_hold, {"R7 wdata ", mode_tag()}, reg_wdata, ref_hold);
      chk(reg_addr == a[AW-1:2], "R7 addr", 32'(reg_addr), 32'(a[AW-1:2]));
      ref_mem[a[AW-1:2]] = ref_hold;
    end else
      chk(reg_we == 1'b0, "R8 no commit", {31'b0, reg_we}, 32'd0);
    @(negedge clk);
    host_wr = 0;
  endtask

  task automatic rd(input logic [AW-1:0] a, input string tag);
    int ln;
    logic [15:0] exp;
    ln = ref_lane(a[1:0]);
    if (ln == 0) ref_snap = ref_mem[a[AW-1:2]];
    if (bus16) begin
      exp = {byte_at(ref_snap, ln), byte_at(ref_snap, ln + 1)};
      if (little_en && addr_inv) exp = {exp[7:0], exp[15:8]};
    end else
      exp = {8'h00, byte_at(ref_snap, ln)};
    @(negedge clk);
    host_addr = a; host_rd = 1;
    #1;
    chk(reg_re == (ln == 0), "R9 reg_re", {31'b0, reg_re}, {31'b0, ln == 0});
    @(negedge clk);
    host_rd = 0;
    chk(host_rdata == exp, tag, 32'(host_rdata), 32'(exp));
  endtask

  function automatic logic [AW-1:0] host_for(input int w, input int ln);
    for (int a = 0; a < 4; a++)
      if (ref_lane(2'(a)) == ln && (!bus16 || a[0] == 1'b0)) return AW'(w * 4 + a);
    return '0;
  endfunction

  task automatic run_mode(input bit le, input bit b16, input bit ai, input int w, input logic [31:0] pat);
    little_en = le; bus16 = b16; addr_inv = ai;
    if (b16) begin
      wr(host_for(w, 0), pat[31:16]);
      wr(host_for(w, 2), pat[15:0]);
    end else
      for (int k = 0; k < 4; k++) wr(host_for(w, k), {8'h00, byte_at(pat, k)});
    chk(mem[w] == ref_mem[w], {mode_tag(), " placement"}, mem[w], ref_mem[w]);
    if (b16) begin
      rd(host_for(w, 0), {mode_tag(), " R6 read"});
      rd(host_for(w, 2), {mode_tag(), " R6 read"});
    end else
      for (int k = 0; k < 4; k++) rd(host_for(w, k), {mode_tag(), " R6 read"});
  endtask

  initial begin
    #(20 * 200000);
    errors++; checks++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    for (int i = 0; i < NW; i++) begin mem[i] = 0; ref_mem[i] = 0; end
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(host_rdata == 16'h0, "R11 rdata", 32'(host_rdata), 32'h0);
    chk(!reg_we && !reg_re, "R11 strobes", {30'b0, reg_we, reg_re}, 32'h0);

    run_mode(0, 0, 0, 1, 32'h11223344);
    run_mode(0, 1, 1, 2, 32'hA1B2C3D4);
    run_mode(1, 0, 0, 3, 32'h55667788);
    run_mode(1, 1, 0, 4, 32'h0F1E2D3C);
    run_mode(1, 1, 1, 5, 32'hCAFEBEEF);
    run_mode(1, 0, 1, 6, 32'h9ABCDEF0);

    // R2 explicit: host byte 0 lands in bits 7:0
    little_en = 1; bus16 = 0; addr_inv = 0;
    wr(AW'(7*4+3), 16'h00E1); wr(AW'(7*4+2), 16'h00E2);
    wr(AW'(7*4+1), 16'h00E3); wr(AW'(7*4+0), 16'h00E4);
    chk(mem[7] == 32'hE1E2E3E4, "R2 integer order", mem[7], 32'hE1E2E3E4);

    // R4 explicit and R6 odd halfword address ignored bit 0
    bus16 = 1; addr_inv = 1;
    wr(AW'(8*4+1), 16'h1234); wr(AW'(8*4+3), 16'h5678);
    chk(mem[8] == 32'h34127856, "R4 R6 swap", mem[8], 32'h34127856);

    // R10 snapshot: poke word between reads
    little_en = 0; bus16 = 0; addr_inv = 0;
    rd(AW'(1*4+0), "R10 first");
    mem[1] = 32'hDEADBEEF;
    rd(AW'(1*4+1), "R10 from snapshot");
    rd(AW'(1*4+3), "R10 from snapshot");
    ref_mem[1] = 32'hDEADBEEF;
    rd(AW'(1*4+0), "R10 refresh");
    rd(AW'(1*4+2), "R10 new snapshot");

    // R8 out of order: last lane first commits with old held lanes
    wr(AW'(9*4+3), 16'h0077);
    chk(mem[9] == ref_mem[9], "R7 early last lane", mem[9], ref_mem[9]);
    wr(AW'(9*4+0), 16'h0011);
    chk(mem[9] == ref_mem[9], "R8 no write", mem[9], ref_mem[9]);

    @(negedge clk);
    chk(host_rdata == 16'(ref_mem[1] >> 8 & 32'hFF), "R9 held", 32'(host_rdata), ref_mem[1] >> 8 & 32'hFF);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule